// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware side of entering an interrupt or exception handler. On a start pulse it latches the event (vector, software/hardware origin, fault kind, optional error code) together with the interrupted context: code selector, instruction pointer, flags, stack selector and stack pointer. It also latches the bases of the interrupt table, the global descriptor table and the task-state area.

It then walks a fixed access sequence on a single 32-bit memory port with a request/acknowledge handshake. First it reads the 8-byte gate. Next it reads the privilege word of the target code descriptor named by the gate. It then decides whether entry is allowed and whether the privilege level changes.

On a privilege change it fetches a new stack from the task-state area and pushes the old stack selector and pointer onto it. In every allowed case it pushes flags, code selector, return pointer and, optionally, the error code. It finishes with a one-cycle done pulse carrying the handler's selector and pointer and the final stack. A refused entry ends with a one-cycle fault pulse carrying the vector, and no memory write is made.

Top module: `intr_entry_seq`

## Requirements
- R1: The gate is read as two words: the low word at `idt_base + vec*8`, then the high word at that address + 4. Gate low word = {selector[31:16], offset[15:0]}; gate high word = {offset[31:16], gate privilege at bits 14:13}.
- R2: The third read fetches the target descriptor's high word at `gdt_base + sel[15:3]*8 + 4`, whose bits 14:13 hold the target privilege.
- R3: With the current privilege (cur_cs[1:0]) numerically below the target privilege, a one-cycle fault pulse with fault_vec = vec is raised, no write is made and done stays low.
- R4: For software events only (sw_int = 1), a gate privilege numerically below the current privilege also raises the fault. For hardware events the gate privilege has no effect.
- R5: When the current privilege differs from the target privilege, the new stack pointer is read at `tss_base + 4 + 8*tdpl` and the new stack selector at `tss_base + 8 + 8*tdpl` (bits 15:0 used). The old stack selector (zero-extended) and then the old stack pointer are pushed onto the new stack.
- R6: When the levels are equal, the task-state area is not read, and pushing starts from cur_sp.
- R7: Pushes continue in the order flags, code selector (zero-extended), return pointer, then the error code only when has_err = 1. Every push first lowers the stack pointer by 4 and then writes at the new value.
- R8: The pushed return pointer is fault_ip when is_fault = 1, otherwise cur_ip.
- R9: On success done pulses for one cycle with new_cs = gate selector, new_ip = gate offset, new_ss = the stack selector in use, and new_sp = the pointer after the last push. Done and fault are never high together.
- R10: A start pulse while a sequence is running is ignored and does not alter the sequence or its results.
- R11: During and after reset, with no start, mem_req, done and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an entry sequence (accepted only when idle) |
| vec | input | 8 | Vector number |
| sw_int | input | 1 | Event is software-generated |
| is_fault | input | 1 | Event is a fault (restart the instruction) |
| has_err | input | 1 | Event supplies an error code |
| err_code | input | 32 | Error code |
| cur_cs | input | 16 | Current code selector; bits 1:0 are the current privilege |
| cur_ip | input | 32 | Pointer to the next instruction |
| fault_ip | input | 32 | Pointer to the faulting instruction |
| cur_flags | input | 32 | Current flags |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| idt_base | input | 32 | Interrupt table base |
| gdt_base | input | 32 | Global descriptor table base |
| tss_base | input | 32 | Task-state area base |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| done | output | 1 | One-cycle success pulse |
| new_cs | output | 16 | Handler code selector, valid with done |
| new_ip | output | 32 | Handler pointer, valid with done |
| new_ss | output | 16 | Stack selector in use, valid with done |
| new_sp | output | 32 | Final stack pointer, valid with done |
| fault | output | 1 | One-cycle protection fault pulse |
| fault_vec | output | 8 | Vector of the refused event, valid with fault |

## Verification
The bench targets the privilege boundaries. A target level just above the current one must fault, and equal levels must not switch stacks. A gate level below the current one must fault only for software events. A design that mixed up the comparison direction or applied the gate check to hardware events would fault on legal entries, or write a frame where it should refuse. The full sequence of reads and writes is compared entry by entry. This catches the following faults: a wrong descriptor slot offset, a skipped stack switch, pushes in the wrong order, a post-decrement instead of a pre-decrement, and a dropped or spurious error code. Directed cases cover the saved pointer for faults and a second start pulse in mid-sequence. A design that re-latched its inputs on that pulse would read the wrong gate.

// File: rtl/ies_pkg.sv
package ies_pkg;
    localparam int WORD_W    = 32;
    localparam int SEL_W     = 16;
    localparam int VEC_W     = 8;
    localparam int PL_W      = 2;
    localparam int PL_LSB    = 13;
    localparam int PUSH_STEP = 4;
    localparam int SLOT_IDX_W = SEL_W - 3;
    localparam int PIDX_W    = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_GLO, S_GHI, S_DHI, S_CHK, S_TSP, S_TSS, S_PUSH, S_DONE, S_FLT
    } ies_state_e;

    typedef enum logic [PIDX_W-1:0] {
        P_OLD_SS = 3'd0, P_OLD_SP = 3'd1, P_FLAGS = 3'd2,
        P_CS     = 3'd3, P_RET    = 3'd4, P_ERR   = 3'd5
    } ies_push_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic              sw;
        logic              has_err;
        logic [WORD_W-1:0] err;
        logic [SEL_W-1:0]  cs;
        logic [WORD_W-1:0] ret;
        logic [WORD_W-1:0] flags;
        logic [SEL_W-1:0]  ss;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] idt;
        logic [WORD_W-1:0] gdt;
        logic [WORD_W-1:0] tss;
    } ies_ctx_t;

    function automatic logic [WORD_W-1:0] slot8(input logic [SLOT_IDX_W-1:0] idx);
        return {{(WORD_W-SLOT_IDX_W-3){1'b0}}, idx, 3'b000};
    endfunction

    function automatic logic [PL_W-1:0] pl_of(input logic [WORD_W-1:0] w);
        return w[PL_LSB +: PL_W];
    endfunction
endpackage

// File: rtl/ies_priv_check.sv
module ies_priv_check
    import ies_pkg::*;
(
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] gate_pl,
    input  logic [PL_W-1:0] tgt_pl,
    input  logic            sw,
    output logic            deny,
    output logic            stack_sw
);
    always_comb begin
        deny     = (cpl < tgt_pl) || (sw && (gate_pl < cpl));
        stack_sw = (cpl != tgt_pl);
    end
endmodule

// File: rtl/ies_push_sel.sv
module ies_push_sel
    import ies_pkg::*;
(
    input  logic [PIDX_W-1:0] idx,
    input  ies_ctx_t          ctx,
    output logic [WORD_W-1:0] data
);
    always_comb begin
        case (ies_push_e'(idx))
            P_OLD_SS: data = {{(WORD_W-SEL_W){1'b0}}, ctx.ss};
            P_OLD_SP: data = ctx.sp;
            P_FLAGS:  data = ctx.flags;
            P_CS:     data = {{(WORD_W-SEL_W){1'b0}}, ctx.cs};
            P_RET:    data = ctx.ret;
            default:  data = ctx.err;
        endcase
    end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import ies_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VEC_W-1:0]  vec,
    input  logic              sw_int,
    input  logic              is_fault,
    input  logic              has_err,
    input  logic [WORD_W-1:0] err_code,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [WORD_W-1:0] fault_ip,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] idt_base,
    input  logic [WORD_W-1:0] gdt_base,
    input  logic [WORD_W-1:0] tss_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [SEL_W-1:0]  new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [SEL_W-1:0]  new_ss,
    output logic [WORD_W-1:0] new_sp,
    output logic              fault,
    output logic [VEC_W-1:0]  fault_vec
);
    localparam int HALF_W = WORD_W / 2;
    localparam logic [WORD_W-1:0] STEP = WORD_W'(PUSH_STEP);
    localparam logic [WORD_W-1:0] HI_OFS = WORD_W'(4);
    localparam logic [WORD_W-1:0] TSS_SP_OFS = WORD_W'(4);
    localparam logic [WORD_W-1:0] TSS_SS_OFS = WORD_W'(8);

    ies_state_e          st;
    ies_ctx_t            ctx;
    logic [WORD_W-1:0]   gate_lo;
    logic [HALF_W-1:0]   gate_off_hi;
    logic [PL_W-1:0]     gate_pl;
    logic [PL_W-1:0]     tgt_pl;
    logic [WORD_W-1:0]   sp_r;
    logic [SEL_W-1:0]    ss_r;
    logic [PIDX_W-1:0]   pidx;
    logic                deny, stack_sw;
    logic [WORD_W-1:0]   push_data;
    logic [PIDX_W-1:0]   last_idx;

    ies_priv_check u_chk (
        .cpl(ctx.cs[PL_W-1:0]), .gate_pl(gate_pl), .tgt_pl(tgt_pl),
        .sw(ctx.sw), .deny(deny), .stack_sw(stack_sw)
    );

    ies_push_sel u_sel (.idx(pidx), .ctx(ctx), .data(push_data));

    assign last_idx = ctx.has_err ? P_ERR : P_RET;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            ctx         <= '0;
            gate_lo     <= '0;
            gate_off_hi <= '0;
            gate_pl     <= '0;
            tgt_pl      <= '0;
            sp_r        <= '0;
            ss_r        <= '0;
            pidx        <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    ctx.vec     <= vec;
                    ctx.sw      <= sw_int;
                    ctx.has_err <= has_err;
                    ctx.err     <= err_code;
                    ctx.cs      <= cur_cs;
                    ctx.ret     <= is_fault ? fault_ip : cur_ip;
                    ctx.flags   <= cur_flags;
                    ctx.ss      <= cur_ss;
                    ctx.sp      <= cur_sp;
                    ctx.idt     <= idt_base;
                    ctx.gdt     <= gdt_base;
                    ctx.tss     <= tss_base;
                    sp_r        <= cur_sp;
                    ss_r        <= cur_ss;
                    st          <= S_GLO;
                end
                S_GLO: if (mem_ack) begin
                    gate_lo <= mem_rdata;
                    st      <= S_GHI;
                end
                S_GHI: if (mem_ack) begin
                    gate_off_hi <= mem_rdata[WORD_W-1:HALF_W];
                    gate_pl     <= pl_of(mem_rdata);
                    st          <= S_DHI;
                end
                S_DHI: if (mem_ack) begin
                    tgt_pl <= pl_of(mem_rdata);
                    st     <= S_CHK;
                end
                S_CHK: begin
                    if (deny) begin
                        st <= S_FLT;
                    end else if (stack_sw) begin
                        st <= S_TSP;
                    end else begin
                        pidx <= P_FLAGS;
                        sp_r <= sp_r - STEP;
                        st   <= S_PUSH;
                    end
                end
                S_TSP: if (mem_ack) begin
                    sp_r <= mem_rdata;
                    st   <= S_TSS;
                end
                S_TSS: if (mem_ack) begin
                    ss_r <= mem_rdata[SEL_W-1:0];
                    pidx <= P_OLD_SS;
                    sp_r <= sp_r - STEP;
                    st   <= S_PUSH;
                end
                S_PUSH: if (mem_ack) begin
                    if (pidx == last_idx) begin
                        st <= S_DONE;
                    end else begin
                        pidx <= pidx + 1'b1;
                        sp_r <= sp_r - STEP;
                    end
                end
                S_DONE:  st <= S_IDLE;
                S_FLT:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            S_GLO: begin
                mem_req  = 1'b1;
                mem_addr = ctx.idt + slot8({{(SLOT_IDX_W-VEC_W){1'b0}}, ctx.vec});
            end
            S_GHI: begin
                mem_req  = 1'b1;
                mem_addr = ctx.idt + slot8({{(SLOT_IDX_W-VEC_W){1'b0}}, ctx.vec}) + HI_OFS;
            end
            S_DHI: begin
                mem_req  = 1'b1;
                mem_addr = ctx.gdt + slot8(gate_lo[WORD_W-1:WORD_W-SLOT_IDX_W]) + HI_OFS;
            end
            S_TSP: begin
                mem_req  = 1'b1;
                mem_addr = ctx.tss + TSS_SP_OFS + slot8({{(SLOT_IDX_W-PL_W){1'b0}}, tgt_pl});
            end
            S_TSS: begin
                mem_req  = 1'b1;
                mem_addr = ctx.tss + TSS_SS_OFS + slot8({{(SLOT_IDX_W-PL_W){1'b0}}, tgt_pl});
            end
            S_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_r;
                mem_wdata = push_data;
            end
            default: ;
        endcase
    end

    assign done      = (st == S_DONE);
    assign fault     = (st == S_FLT);
    assign fault_vec = ctx.vec;
    assign new_cs    = gate_lo[WORD_W-1:HALF_W];
    assign new_ip    = {gate_off_hi, gate_lo[HALF_W-1:0]};
    assign new_ss    = ss_r;
    assign new_sp    = sp_r;
endmodule

// File: rtl/ies_checker.sv
module ies_checker
    import ies_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              done,
    input logic              fault
);
    logic [WORD_W-1:0] last_waddr;
    logic              have_w;
    logic              any_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_waddr <= '0;
            have_w     <= 1'b0;
            any_w      <= 1'b0;
        end else if (done || fault) begin
            have_w <= 1'b0;
            any_w  <= 1'b0;
        end else if (mem_req && mem_we && mem_ack) begin
            last_waddr <= mem_addr;
            have_w     <= 1'b1;
            any_w      <= 1'b1;
        end
    end

    assert_push_step_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && have_w) |-> (mem_addr == last_waddr - WORD_W'(PUSH_STEP)));

    assert_fault_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
        fault |-> !any_w);

    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind intr_entry_seq ies_checker u_ies_checker (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .done(done), .fault(fault)
);

// File: tb/sim_intr_entry_seq.sv
`timescale 1ns/1ps
module sim_intr_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  vec = '0;
    logic        sw_int = 1'b0, is_fault = 1'b0, has_err = 1'b0;
    logic [31:0] err_code = '0, cur_ip = '0, fault_ip = '0, cur_flags = '0, cur_sp = '0;
    logic [15:0] cur_cs = '0, cur_ss = '0;
    logic [31:0] idt_base = 32'h0000_1000, gdt_base = 32'h0000_2000, tss_base = 32'h0000_3000;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        done, fault;
    logic [15:0] new_cs, new_ss;
    logic [31:0] new_ip, new_sp;
    logic [7:0]  fault_vec;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [logic [31:0]];
    logic [64:0] log_q [$];
    logic [64:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    intr_entry_seq u0 (
        .clk(clk), .rst(rst), .start(start), .vec(vec), .sw_int(sw_int),
        .is_fault(is_fault), .has_err(has_err), .err_code(err_code),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .fault_ip(fault_ip), .cur_flags(cur_flags),
        .cur_ss(cur_ss), .cur_sp(cur_sp), .idt_base(idt_base), .gdt_base(gdt_base),
        .tss_base(tss_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
        .new_cs(new_cs), .new_ip(new_ip), .new_ss(new_ss), .new_sp(new_sp),
        .fault(fault), .fault_vec(fault_vec)
    );

    // memory model: random acknowledge latency, logs every accepted access
    always @(negedge clk) begin
        if (!rst && mem_req && ($urandom % 4 != 0)) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                log_q.push_back({1'b1, mem_addr, mem_wdata});
            end else begin
                mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                log_q.push_back({1'b0, mem_addr, mem_rdata});
            end
        end else begin
            mem_ack   = 1'b0;
            mem_rdata = 32'hDEAD_BEEF;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] gate_hi(input logic [31:0] off, input logic [1:0] pl);
        return {off[31:16], 1'b1, pl, 13'h0};
    endfunction

    task automatic expect_acc(input bit we, input logic [31:0] a, input logic [31:0] d, input string t);
        exp_q.push_back({we, a, d});
        tag_q.push_back(t);
    endtask

    task automatic run_case(
        input logic [7:0] v, input bit sw, input bit isf, input bit herr, input logic [31:0] err,
        input logic [15:0] cs, input logic [31:0] ip, input logic [31:0] fip, input logic [31:0] fl,
        input logic [15:0] ss, input logic [31:0] sp, input logic [15:0] gsel, input logic [31:0] goff,
        input logic [1:0] gpl, input logic [1:0] tpl, input logic [31:0] nsp, input logic [15:0] nss,
        input bit glitch);
        logic [1:0]  cpl;
        logic [31:0] ga, da, s;
        bit          flt, swc, got, logok;
        string       rq;
        cpl = cs[1:0];
        ga  = idt_base + {21'h0, v, 3'b000};
        da  = gdt_base + {16'h0, gsel[15:3], 3'b000} + 32'd4;
        mem.delete();
        mem[ga]        = {gsel, goff[15:0]};
        mem[ga + 32'd4] = gate_hi(goff, gpl);
        mem[da]        = {17'h0, tpl, 13'h0};
        mem[tss_base + 32'd4 + {27'h0, tpl, 3'b000}] = nsp;
        mem[tss_base + 32'd8 + {27'h0, tpl, 3'b000}] = {16'hA5C3, nss};
        log_q.delete(); exp_q.delete(); tag_q.delete();
        flt = (cpl < tpl) || (sw && (gpl < cpl));
        swc = (cpl != tpl);
        expect_acc(1'b0, ga, mem[ga], "R1");
        expect_acc(1'b0, ga + 32'd4, mem[ga + 32'd4], "R1");
        expect_acc(1'b0, da, mem[da], "R2");
        s = sp;
        if (!flt) begin
            if (swc) begin
                expect_acc(1'b0, tss_base + 32'd4 + {27'h0, tpl, 3'b000}, nsp, "R5");
                expect_acc(1'b0, tss_base + 32'd8 + {27'h0, tpl, 3'b000}, {16'hA5C3, nss}, "R5");
                s = nsp;
                s -= 4; expect_acc(1'b1, s, {16'h0, ss}, "R5");
                s -= 4; expect_acc(1'b1, s, sp, "R5");
                s -= 4; expect_acc(1'b1, s, fl, "R7");
            end else begin
                s -= 4; expect_acc(1'b1, s, fl, "R6");
            end
            s -= 4; expect_acc(1'b1, s, {16'h0, cs}, "R7");
            s -= 4; expect_acc(1'b1, s, isf ? fip : ip, "R8");
            if (herr) begin s -= 4; expect_acc(1'b1, s, err, "R7"); end
        end
        @(negedge clk);
        vec = v; sw_int = sw; is_fault = isf; has_err = herr; err_code = err;
        cur_cs = cs; cur_ip = ip; fault_ip = fip; cur_flags = fl; cur_ss = ss; cur_sp = sp;
        start = 1'b1;
        got = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (glitch && c == 3) begin
                start = 1'b1; vec = ~v; cur_sp = 32'h0; cur_cs = 16'h0003; sw_int = ~sw;
            end else begin
                start = 1'b0;
            end
            if (done || fault) begin got = 1; break; end
        end
        start = 1'b0;
        chk(got, "R9", {63'h0, got}, 64'h1);
        if (!got) return;
        if (flt) begin
            rq = (cpl < tpl) ? "R3" : "R4";
            chk(fault && !done && fault_vec == v, rq, {fault, done, 54'h0, fault_vec}, {2'b10, 54'h0, v});
        end else begin
            chk(done && !fault, "R9", {62'h0, done, fault}, 64'h2);
            chk(new_cs == gsel && new_ip == goff, "R9", {new_cs, new_ip}, {gsel, goff});
            chk(new_ss == (swc ? nss : ss) && new_sp == s, "R9", {new_ss, new_sp}, {(swc ? nss : ss), s});
        end
        logok = (log_q.size() == exp_q.size());
        chk(logok, flt ? "R3" : "R7", 64'(log_q.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++) begin
            chk(log_q[i] == exp_q[i], tag_q[i], log_q[i][63:0], exp_q[i][63:0]);
            if (log_q[i] != exp_q[i]) logok = 0;
        end
        if (glitch) chk(logok, "R10", {63'h0, logok}, 64'h1);
        @(negedge clk);
        chk(!done && !fault, "R9", {62'h0, done, fault}, 64'h0);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk(!mem_req && !done && !fault, "R11", {61'h0, mem_req, done, fault}, 64'h0);
        @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_req && !done && !fault, "R11", {61'h0, mem_req, done, fault}, 64'h0);

        // same level, hardware, error code (R6, R7)
        run_case(8'd14, 0, 0, 1, 32'h0000_0006, 16'h0010, 32'h0040_1000, 32'h0040_0FF0,
                 32'h0000_0202, 16'h0018, 32'h0000_9000, 16'h0010, 32'hC010_2000, 2'd0, 2'd0,
                 32'h0, 16'h0, 0);
        // level change by software gate (R5, R4 pass)
        run_case(8'h80, 1, 0, 0, 32'h0, 16'h0023, 32'h0804_8000, 32'h0, 32'h0000_0246,
                 16'h002B, 32'hBFFF_F000, 16'h0060, 32'hC000_1234, 2'd3, 2'd0,
                 32'h0000_C000, 16'h0068, 0);
        // software gate privilege too low (R4)
        run_case(8'd3, 1, 0, 0, 32'h0, 16'h0023, 32'h1000, 32'h0, 32'h2, 16'h2B, 32'h8000,
                 16'h0010, 32'h1111_2222, 2'd0, 2'd0, 32'h0, 16'h0, 0);
        // same gate from hardware ignores gate privilege (R4)
        run_case(8'd3, 0, 0, 0, 32'h0, 16'h0023, 32'h1000, 32'h0, 32'h2, 16'h2B, 32'h8000,
                 16'h0010, 32'h1111_2222, 2'd0, 2'd0, 32'h0000_7000, 16'h0030, 0);
        // target more privileged-numbered than current (R3)
        run_case(8'd255, 0, 0, 1, 32'h1, 16'h0011, 32'h1000, 32'h0, 32'h2, 16'h18, 32'h8000,
                 16'h0033, 32'h5555_6666, 2'd3, 2'd2, 32'h0, 16'h0, 0);
        // fault: saved pointer is the faulting instruction (R8)
        run_case(8'd0, 0, 1, 0, 32'h0, 16'h0008, 32'h0000_5008, 32'h0000_5004, 32'h0,
                 16'h0010, 32'h0000_6000, 16'h0008, 32'h0000_ABCD, 2'd0, 2'd0,
                 32'h0, 16'h0, 0);
        // start pulse in mid-sequence is ignored (R10)
        run_case(8'd33, 0, 0, 1, 32'hEE, 16'h0012, 32'h4000, 32'h0, 32'h1, 16'h1A, 32'h7700,
                 16'h0048, 32'h0BAD_F00D, 2'd1, 2'd1, 32'h0, 16'h0, 1);

        for (int n = 0; n < 40; n++) begin
            logic [1:0] cp, tp, gp;
            logic [15:0] cs;
            cp = 2'($urandom); tp = 2'($urandom); gp = 2'($urandom);
            if ($urandom % 3 != 0 && tp > cp) tp = cp;
            cs = {13'($urandom), 1'b0, cp};
            run_case(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), $urandom,
                     cs, $urandom, $urandom, $urandom, 16'($urandom),
                     {16'h00F0, 12'($urandom), 4'h0}, 16'($urandom), $urandom,
                     gp, tp, {16'h00E0, 12'($urandom), 4'h0}, 16'($urandom), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule